// File: doc/BRIEF.md
# Pipelined Burst Synchronous Static Memory

This block is a clocked static memory whose data word is split into byte lanes of nine bits each, the ninth bit of a lane being its parity bit. A cycle is opened by one of two address strobes: the processor strobe always starts a read, while the controller strobe samples the write enables on the same edge and can start either a read or a write. Three chip selects (one master select, one active-high and one active-low select) gate the strobes, and the master select gates them differently for the two strobes. Once a cycle is open and both strobes are idle, an advance input either moves to the next burst address or holds the current one. The next burst address is produced outside the block from the current address, which the block exposes.

Read data leaves through either a registered output stage (pipelined mode) or straight from the array (flow-through mode), chosen by a static input. Output drive is a separate enable signal that follows the asynchronous output enable, and it is forced off during writes, deselect and sleep. The sleep input freezes all accesses while the contents are kept.

Top module: `burst_sram`

## Requirements
- R1: A processor strobe low with the master select low and the other two selects active loads `addr_i` and opens a read cycle, whatever the write enables and the controller strobe do on that edge.
- R2: With the master select high, the processor strobe is ignored; the edge then behaves as if that strobe were high.
- R3: The controller strobe opens a cycle only when the processor strobe is not in effect on that edge and all three selects are active; it loads `addr_i` and samples the write enables on that same edge.
- R4: Write decode: `wr_all_n` low writes every lane; with `wr_all_n` high and `wr_byte_n` low, each lane whose `lane_we_n` bit is low is written; otherwise the edge is a read. Lane 0 is `d_i[8:0]`, lane 1 is `d_i[17:9]`, and a lane is written only as a whole.
- R5: In an open cycle with both strobes high, `adv_n` low moves `cur_addr_o` to `burst_next_i` and `adv_n` high keeps it; the write enables are sampled on every such edge and a write goes to the resulting address.
- R6: In pipelined mode (`flow_thru_n` high), the data of the address registered at one edge appears on `q_o` after the following edge.
- R7: In flow-through mode (`flow_thru_n` low), the data of the address registered at an edge appears on `q_o` within the same cycle.
- R8: `q_oe_o` is low during any cycle whose edge sampled a write; otherwise in read mode it follows `oe_n` combinationally, with no clock edge needed.
- R9: A strobe seen with a failing select deselects the block; `q_oe_o` drops after that edge in flow-through mode and after one more edge in pipelined mode.
- R10: While `sleep_i` is high no state changes, nothing is written, `q_oe_o` is low, and the contents are kept.
- R11: After reset no cycle is open, `q_oe_o` is low and all words read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flow_thru_n | input | 1 | Static mode select: low gives flow-through, high gives pipelined |
| sleep_i | input | 1 | Sleep: freezes accesses, keeps contents |
| cs_main_n | input | 1 | Master chip select, active low |
| cs_hi | input | 1 | Chip select, active high |
| cs_lo_n | input | 1 | Chip select, active low |
| strobe_proc_n | input | 1 | Processor address strobe, active low |
| strobe_ctrl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| addr_i | input | AW | External address |
| burst_next_i | input | AW | Next burst address from the external generator |
| cur_addr_o | output | AW | Address of the open cycle |
| wr_all_n | input | 1 | Global write enable, active low |
| wr_byte_n | input | 1 | Byte write enable, active low |
| lane_we_n | input | LANES | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| d_i | input | LANES*LW | Write data |
| q_o | output | LANES*LW | Read data |
| q_oe_o | output | 1 | Output drive enable for the data bus |

## Verification
The bench builds the block with its defaults: six address bits (64 words), two lanes of nine bits, so random addresses revisit written words often and every lane mask is reachable. Each mode is run in turn with a reset in between, so both the registered and the direct output path face the same write, suspend, advance and deselect patterns. The burst generator wraps the two low address bits, which puts burst wrap-around and writes to the word just read within reach.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

    typedef enum logic [2:0] {
        CYC_IDLE,
        CYC_LOAD_P,
        CYC_LOAD_C,
        CYC_CONT,
        CYC_HOLD,
        CYC_DESEL,
        CYC_SLEEP
    } cyc_kind_e;

endpackage

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
    import burst_sram_pkg::*;
#(
    parameter int AW    = 6,
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_i,
    input  logic             cs_main_n,
    input  logic             cs_hi,
    input  logic             cs_lo_n,
    input  logic             strobe_proc_n,
    input  logic             strobe_ctrl_n,
    input  logic             adv_n,
    input  logic [AW-1:0]    addr_i,
    input  logic [AW-1:0]    burst_next_i,
    input  logic             wr_all_n,
    input  logic             wr_byte_n,
    input  logic [LANES-1:0] lane_we_n,
    output logic             act_q,
    output logic             wr_q,
    output logic [AW-1:0]    addr_q,
    output logic [LANES-1:0] lane_wen,
    output logic [AW-1:0]    wr_addr
);

    typedef struct packed {
        logic          act;
        logic          wr;
        logic [AW-1:0] addr;
    } ctl_t;

    ctl_t       ctl_d, ctl_q;
    cyc_kind_e  kind_d;
    logic [LANES-1:0] mask_d;
    logic       proc_hit_d;
    logic       side_ok_d;

    always_comb begin
        ctl_d      = ctl_q;
        kind_d     = CYC_IDLE;
        side_ok_d  = cs_hi && !cs_lo_n;
        proc_hit_d = !strobe_proc_n && !cs_main_n;

        if (!wr_all_n)       mask_d = '1;
        else if (!wr_byte_n) mask_d = ~lane_we_n;
        else                 mask_d = '0;

        if (sleep_i) begin
            kind_d = CYC_SLEEP;
        end else if (proc_hit_d) begin
            if (side_ok_d) begin
                kind_d       = CYC_LOAD_P;
                ctl_d.act    = 1'b1;
                ctl_d.wr     = 1'b0;
                ctl_d.addr   = addr_i;
            end else begin
                kind_d    = CYC_DESEL;
                ctl_d.act = 1'b0;
                ctl_d.wr  = 1'b0;
            end
        end else if (!strobe_ctrl_n) begin
            if (side_ok_d && !cs_main_n) begin
                kind_d     = CYC_LOAD_C;
                ctl_d.act  = 1'b1;
                ctl_d.wr   = |mask_d;
                ctl_d.addr = addr_i;
            end else begin
                kind_d    = CYC_DESEL;
                ctl_d.act = 1'b0;
                ctl_d.wr  = 1'b0;
            end
        end else if (ctl_q.act) begin
            kind_d   = adv_n ? CYC_HOLD : CYC_CONT;
            ctl_d.wr = |mask_d;
            if (!adv_n) ctl_d.addr = burst_next_i;
        end

        if ((kind_d == CYC_LOAD_C || kind_d == CYC_CONT || kind_d == CYC_HOLD) && ctl_d.wr)
            lane_wen = mask_d;
        else
            lane_wen = '0;
        wr_addr = ctl_d.addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign act_q  = ctl_q.act;
    assign wr_q   = ctl_q.wr;
    assign addr_q = ctl_q.addr;

endmodule

// File: rtl/burst_sram_lane.sv
module burst_sram_lane #(
    parameter int AW = 6,
    parameter int LW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [LW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [LW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [LW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/burst_sram_outpath.sv
module burst_sram_outpath #(
    parameter int DW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sleep_i,
    input  logic          flow_thru_n,
    input  logic          act_q,
    input  logic          wr_q,
    input  logic          oe_n,
    input  logic [DW-1:0] rd_word,
    output logic [DW-1:0] q_o,
    output logic          q_oe_o
);

    typedef struct packed {
        logic          vld;
        logic [DW-1:0] data;
    } pipe_t;

    pipe_t pipe_d, pipe_q;
    logic  src_vld_d;

    always_comb begin
        pipe_d = pipe_q;
        if (!sleep_i) begin
            pipe_d.vld  = act_q && !wr_q;
            pipe_d.data = rd_word;
        end
        src_vld_d = flow_thru_n ? pipe_q.vld : act_q;
        q_o       = flow_thru_n ? pipe_q.data : rd_word;
        q_oe_o    = !oe_n && !sleep_i && !wr_q && src_vld_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

endmodule

// File: rtl/burst_sram.sv
module burst_sram #(
    parameter int AW    = 6,
    parameter int LANES = 2,
    parameter int LW    = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flow_thru_n,
    input  logic                sleep_i,
    input  logic                cs_main_n,
    input  logic                cs_hi,
    input  logic                cs_lo_n,
    input  logic                strobe_proc_n,
    input  logic                strobe_ctrl_n,
    input  logic                adv_n,
    input  logic [AW-1:0]       addr_i,
    input  logic [AW-1:0]       burst_next_i,
    output logic [AW-1:0]       cur_addr_o,
    input  logic                wr_all_n,
    input  logic                wr_byte_n,
    input  logic [LANES-1:0]    lane_we_n,
    input  logic                oe_n,
    input  logic [LANES*LW-1:0] d_i,
    output logic [LANES*LW-1:0] q_o,
    output logic                q_oe_o
);

    localparam int DW = LANES * LW;

    logic             cyc_act;
    logic             cyc_wr;
    logic [AW-1:0]    cyc_addr;
    logic [LANES-1:0] lane_wen;
    logic [AW-1:0]    wr_addr;
    logic [DW-1:0]    rd_word;

    burst_sram_ctrl #(.AW(AW), .LANES(LANES)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .sleep_i      (sleep_i),
        .cs_main_n    (cs_main_n),
        .cs_hi        (cs_hi),
        .cs_lo_n      (cs_lo_n),
        .strobe_proc_n(strobe_proc_n),
        .strobe_ctrl_n(strobe_ctrl_n),
        .adv_n        (adv_n),
        .addr_i       (addr_i),
        .burst_next_i (burst_next_i),
        .wr_all_n     (wr_all_n),
        .wr_byte_n    (wr_byte_n),
        .lane_we_n    (lane_we_n),
        .act_q        (cyc_act),
        .wr_q         (cyc_wr),
        .addr_q       (cyc_addr),
        .lane_wen     (lane_wen),
        .wr_addr      (wr_addr)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        burst_sram_lane #(.AW(AW), .LW(LW)) u_lane (
            .clk  (clk),
            .rst_n(rst_n),
            .we   (lane_wen[g]),
            .waddr(wr_addr),
            .wdata(d_i[g*LW +: LW]),
            .raddr(cyc_addr),
            .rdata(rd_word[g*LW +: LW])
        );
    end

    burst_sram_outpath #(.DW(DW)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep_i    (sleep_i),
        .flow_thru_n(flow_thru_n),
        .act_q      (cyc_act),
        .wr_q       (cyc_wr),
        .oe_n       (oe_n),
        .rd_word    (rd_word),
        .q_o        (q_o),
        .q_oe_o     (q_oe_o)
    );

    assign cur_addr_o = cyc_addr;

endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sleep_i,
    input logic          cs_main_n,
    input logic          cs_hi,
    input logic          cs_lo_n,
    input logic          strobe_proc_n,
    input logic          strobe_ctrl_n,
    input logic          adv_n,
    input logic [AW-1:0] addr_i,
    input logic [AW-1:0] burst_next_i,
    input logic [AW-1:0] cur_addr_o,
    input logic          q_oe_o,
    input logic          cyc_act,
    input logic          cyc_wr
);

    logic proc_load;
    logic idle_strobes;
    assign proc_load    = !sleep_i && !strobe_proc_n && !cs_main_n && cs_hi && !cs_lo_n;
    assign idle_strobes = !sleep_i && strobe_ctrl_n && (strobe_proc_n || cs_main_n) && cyc_act;

    a_r1_proc_loads_addr: assert property (@(posedge clk) disable iff (!rst_n)
        proc_load |=> cur_addr_o == $past(addr_i));

    a_r1_proc_is_read: assert property (@(posedge clk) disable iff (!rst_n)
        proc_load |=> !cyc_wr);

    a_r5_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_strobes && adv_n) |=> $stable(cur_addr_o));

    a_r5_advance_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_strobes && !adv_n) |=> cur_addr_o == $past(burst_next_i));

    a_r8_write_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_wr |-> !q_oe_o);

    a_r9_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_i && (!strobe_ctrl_n || (!strobe_proc_n && !cs_main_n)) && !(cs_hi && !cs_lo_n))
        |=> !cyc_act);

    a_r10_sleep_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |-> !q_oe_o);

    a_r10_sleep_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |=> $stable(cur_addr_o) && $stable(cyc_act));

endmodule

bind burst_sram burst_sram_chk #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sleep_i      (sleep_i),
    .cs_main_n    (cs_main_n),
    .cs_hi        (cs_hi),
    .cs_lo_n      (cs_lo_n),
    .strobe_proc_n(strobe_proc_n),
    .strobe_ctrl_n(strobe_ctrl_n),
    .adv_n        (adv_n),
    .addr_i       (addr_i),
    .burst_next_i (burst_next_i),
    .cur_addr_o   (cur_addr_o),
    .q_oe_o       (q_oe_o),
    .cyc_act      (cyc_act),
    .cyc_wr       (cyc_wr)
);

// File: tb/burst_sram_bench.sv
module burst_sram_bench;

    localparam int AW    = 6;
    localparam int LANES = 2;
    localparam int LW    = 9;
    localparam int DW    = LANES * LW;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flow_thru_n = 1'b1;
    logic sleep_i, cs_main_n, cs_hi, cs_lo_n, strobe_proc_n, strobe_ctrl_n, adv_n;
    logic [AW-1:0] addr_i, burst_next_i, cur_addr_o;
    logic wr_all_n, wr_byte_n, oe_n, q_oe_o;
    logic [LANES-1:0] lane_we_n;
    logic [DW-1:0] d_i, q_o;

    int tests = 0;
    int fails = 0;
    string cur_req = "R11";

    logic [DW-1:0] m_mem [DEPTH];
    logic          m_act, m_wr, m_pvld;
    logic [AW-1:0] m_addr;
    logic [DW-1:0] m_pdata;

    always #4 clk = ~clk;

    burst_sram #(.AW(AW), .LANES(LANES), .LW(LW)) u_burst_sram (.*);

    function automatic logic [AW-1:0] nxt_burst(logic [AW-1:0] a);
        return {a[AW-1:2], 2'(a[1:0] + 2'd1)};
    endfunction

    assign burst_next_i = nxt_burst(cur_addr_o);

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
        m_act = 0; m_wr = 0; m_pvld = 0; m_addr = '0; m_pdata = '0;
    endtask

    task automatic model_edge();
        logic [LANES-1:0] wm;
        if (sleep_i) return;
        m_pdata = m_mem[m_addr];
        m_pvld  = m_act && !m_wr;
        if (!wr_all_n)       wm = '1;
        else if (!wr_byte_n) wm = ~lane_we_n;
        else                 wm = '0;
        if (!strobe_proc_n && !cs_main_n) begin
            m_wr = 0;
            m_act = cs_hi && !cs_lo_n;
            if (m_act) m_addr = addr_i;
        end else if (!strobe_ctrl_n) begin
            m_act = cs_hi && !cs_lo_n && !cs_main_n;
            m_wr  = m_act && (|wm);
            if (m_act) m_addr = addr_i;
        end else if (m_act) begin
            if (!adv_n) m_addr = nxt_burst(m_addr);
            m_wr = |wm;
        end
        if (m_act && m_wr)
            for (int l = 0; l < LANES; l++)
                if (wm[l]) m_mem[m_addr][l*LW +: LW] = d_i[l*LW +: LW];
    endtask

    function automatic logic exp_oe();
        return !oe_n && !sleep_i && !m_wr && (flow_thru_n ? m_pvld : m_act);
    endfunction

    task automatic compare();
        chk({cur_req, " drive enable (R8)"}, 32'(q_oe_o), 32'(exp_oe()));
        chk({cur_req, " current address (R5)"}, 32'(cur_addr_o), 32'(m_addr));
        if (exp_oe()) begin
            if (flow_thru_n) chk({cur_req, " pipelined data (R6)"}, 32'(q_o), 32'(m_pdata));
            else             chk({cur_req, " flow-through data (R7)"}, 32'(q_o), 32'(m_mem[m_addr]));
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic set_idle();
        sleep_i = 0; cs_main_n = 0; cs_hi = 1; cs_lo_n = 0;
        strobe_proc_n = 1; strobe_ctrl_n = 1; adv_n = 1;
        wr_all_n = 1; wr_byte_n = 1; lane_we_n = '1; oe_n = 0;
    endtask

    task automatic proc_load(logic [AW-1:0] a);
        set_idle(); strobe_proc_n = 0; addr_i = a; cycle();
    endtask

    task automatic ctrl_write(logic [AW-1:0] a, logic all_n, logic byte_n,
                              logic [LANES-1:0] lanes_n, logic [DW-1:0] d);
        set_idle(); strobe_ctrl_n = 0; addr_i = a;
        wr_all_n = all_n; wr_byte_n = byte_n; lane_we_n = lanes_n; d_i = d; cycle();
    endtask

    task automatic oe_async();
        logic e;
        e = exp_oe();
        oe_n = 1; #1;
        chk("R8 async disable", 32'(q_oe_o), 32'(0));
        oe_n = 0; #1;
        chk("R8 async enable", 32'(q_oe_o), 32'(e));
    endtask

    task automatic run_mode(logic ft_n);
        rst_n = 0; flow_thru_n = ft_n; set_idle(); addr_i = '0; d_i = '0;
        model_reset();
        repeat (2) @(negedge clk);
        cur_req = "R11";
        chk("R11 reset drive off", 32'(q_oe_o), 32'(0));
        rst_n = 1;
        @(negedge clk);

        cur_req = "R1";
        set_idle(); strobe_proc_n = 0; strobe_ctrl_n = 0; wr_all_n = 0;
        addr_i = 6'd5; d_i = 18'h3ABCD; cycle();
        set_idle(); cycle(); cycle();
        chk("R1 proc strobe wrote nothing", 32'(m_mem[5]), 32'(0));

        cur_req = "R3";
        ctrl_write(6'd9, 1'b0, 1'b1, 2'b11, 18'h2A5A5);
        proc_load(6'd9); set_idle(); cycle();
        oe_async();

        cur_req = "R4";
        ctrl_write(6'd12, 1'b1, 1'b0, 2'b10, 18'h1FFFF);
        ctrl_write(6'd13, 1'b1, 1'b0, 2'b01, 18'h3FE00);
        ctrl_write(6'd14, 1'b1, 1'b1, 2'b00, 18'h12345);
        proc_load(6'd12); set_idle(); cycle();
        proc_load(6'd13); set_idle(); cycle();
        proc_load(6'd14); set_idle(); cycle();

        cur_req = "R5";
        ctrl_write(6'd22, 1'b0, 1'b1, 2'b11, 18'h00111);
        set_idle(); adv_n = 0; wr_all_n = 0; d_i = 18'h00222; cycle();
        set_idle(); adv_n = 1; wr_all_n = 0; d_i = 18'h00333; cycle();
        set_idle(); adv_n = 0; wr_all_n = 0; d_i = 18'h00444; cycle();
        set_idle(); adv_n = 0; wr_all_n = 0; d_i = 18'h00555; cycle();
        proc_load(6'd20);
        for (int i = 0; i < 5; i++) begin set_idle(); adv_n = (i == 2); cycle(); end

        cur_req = "R2";
        proc_load(6'd9);
        set_idle(); strobe_proc_n = 0; cs_main_n = 1; addr_i = 6'd40; adv_n = 0; cycle();
        set_idle(); cycle();
        chk("R2 blocked strobe kept burst", 32'(cur_addr_o), 32'(nxt_burst(6'd9)));

        cur_req = "R9";
        set_idle(); strobe_ctrl_n = 0; cs_main_n = 1; addr_i = 6'd3; cycle();
        set_idle(); cycle();
        chk("R9 deselected drive off", 32'(q_oe_o), 32'(0));
        proc_load(6'd22);
        set_idle(); strobe_proc_n = 0; cs_lo_n = 1; cycle();
        set_idle(); cycle();
        chk("R9 deselect via side select", 32'(q_oe_o), 32'(0));

        cur_req = "R10";
        proc_load(6'd30);
        set_idle(); sleep_i = 1; strobe_ctrl_n = 0; addr_i = 6'd30; wr_all_n = 0; d_i = 18'h3FFFF; cycle();
        chk("R10 sleep drive off", 32'(q_oe_o), 32'(0));
        set_idle(); cycle(); cycle();
        chk("R10 sleep wrote nothing", 32'(m_mem[30]), 32'(0));

        cur_req = "random";
        for (int n = 0; n < 1500; n++) begin
            int r;
            r = int'($urandom % 16);
            set_idle();
            addr_i = AW'($urandom); d_i = DW'($urandom);
            adv_n = 1'($urandom); lane_we_n = LANES'($urandom);
            wr_byte_n = 1'($urandom); wr_all_n = ($urandom % 4) != 0;
            oe_n = ($urandom % 8) == 0;
            if (($urandom % 8) == 0) begin
                cs_main_n = 1'($urandom); cs_hi = 1'($urandom); cs_lo_n = 1'($urandom);
            end
            if (r == 0)      sleep_i = 1;
            else if (r < 4)  strobe_proc_n = 0;
            else if (r < 7)  strobe_ctrl_n = 0;
            cycle();
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        run_mode(1'b1);
        run_mode(1'b0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        fails++;
        tests++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule